// File: doc/BRIEF.md
# Exclusive Access Monitor (single core)

This block keeps the reservation that one core holds for a load-reserve / store-conditional pair. Each request gives an access kind, a base register index and value, an index value and a transfer size. The block forms the effective address, updates its reservation, and decides whether a store-conditional may commit. The local verdict is combined with a verdict from an external multi-core tracker to make a status code and a one-cycle write strobe to memory.

The reservation is held in a state bit (free or reserved), a tagged address and a tagged size. Any plain access drops the reservation. A store-conditional always uses the reservation up, whether or not it commits. A load-reserve also returns its read data, zero-extended to the transfer size, so the core can compare the old value before it tries the conditional store.

Top module: `excl_monitor`

## Requirements
- R1: After reset the reservation is free, with tagged address 0 and tagged size "none" (code 0). All registered outputs are 0. A store-conditional issued first after reset, even at address 0 with size code 0, fails.
- R2: A load-reserve (kind code 2) reserves its effective address and size, and replaces any earlier tag. A store-conditional (kind code 3) with the same address and size then passes locally.
- R3: A plain load (kind code 0) to any address drops a held reservation.
- R4: A plain store (kind code 1) to any address drops a held reservation.
- R5: A store-conditional passes only if both the address and the size match the tag. Pass or fail, it leaves the reservation free, so a second store-conditional fails.
- R6: A store-conditional made while no reservation is held fails locally.
- R7: `mem_we` pulses only when both the local verdict and `global_pass` are true. The status code is 0 on commit and 1 on failure. `local_pass` reports the local verdict alone.
- R8: `status_valid`, `status_code`, `local_pass` and `mem_we` change in the cycle after a store-conditional request and last one cycle. `mem_addr` carries the effective address. `mem_wdata` carries the store data with the bits above the size cleared. Size codes: 1 byte, 2 halfword, 3 word.
- R9: The effective address is `rb_val` plus the base. The base is zero when `ra_idx` is 0 and `ra_val` otherwise.
- R10: A load-reserve raises `ld_valid` for one cycle in the following cycle. `ld_data` is `mem_rdata` zero-extended from the request size.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 2 | 0 load, 1 store, 2 load-reserve, 3 store-conditional |
| req_size | input | 2 | 0 none, 1 byte, 2 halfword, 3 word |
| ra_idx | input | 5 | Base register index; 0 selects a zero base |
| ra_val | input | 32 | Base register value |
| rb_val | input | 32 | Index register value |
| st_data | input | 32 | Store-conditional data |
| mem_rdata | input | 32 | Memory read data for a load-reserve |
| global_pass | input | 1 | Verdict of the multi-core tracker |
| status_valid | output | 1 | Store-conditional result present |
| status_code | output | 1 | 0 committed, 1 failed |
| local_pass | output | 1 | Local reservation verdict |
| mem_we | output | 1 | One-cycle memory write strobe |
| mem_addr | output | 32 | Write address |
| mem_wdata | output | 32 | Size-masked write data |
| ld_valid | output | 1 | Load-reserve data present |
| ld_data | output | 32 | Zero-extended load-reserve data |

## Verification
The bench targets the cases where a monitor that compared only addresses would wrongly commit: a matching address with a different size, and a re-reservation that moves the tag. It checks that plain loads and stores to unrelated addresses still break a reservation. A monitor that filtered these by address would let a later store-conditional commit. It checks that a failed store-conditional, including one vetoed by the global tracker, still uses up the reservation; a design that kept it would commit on a retry. It also covers a zero base index that must ignore `ra_val`, an idle cycle that must not disturb the reservation, and a reset in the middle of a reservation.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD     = 2'd0,
    ACC_STORE    = 2'd1,
    ACC_LOAD_EX  = 2'd2,
    ACC_STORE_EX = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    XSZ_NONE = 2'd0,
    XSZ_BYTE = 2'd1,
    XSZ_HALF = 2'd2,
    XSZ_WORD = 2'd3
  } xfer_size_e;

endpackage

// File: rtl/excl_ea_gen.sv
module excl_ea_gen #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [ADDR_W-1:0] ra_val,
  input  logic [ADDR_W-1:0] rb_val,
  output logic [ADDR_W-1:0] eff_addr
);
  logic [ADDR_W-1:0] base;

  // index zero selects a zero base, not register contents
  always_comb begin
    base     = (ra_idx == '0) ? '0 : ra_val;
    eff_addr = base + rb_val;
  end
endmodule

// File: rtl/excl_resv.sv
module excl_resv
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  acc_kind_e         acc_kind,
  input  logic [ADDR_W-1:0] acc_addr,
  input  xfer_size_e        acc_size,
  output logic              resv_held,
  output logic              local_ok
);
  logic              held_q, held_d;
  logic [ADDR_W-1:0] tag_addr_q, tag_addr_d;
  xfer_size_e        tag_size_q, tag_size_d;

  always_comb begin
    held_d     = held_q;
    tag_addr_d = tag_addr_q;
    tag_size_d = tag_size_q;
    local_ok   = 1'b0;
    if (acc_valid) begin
      unique case (acc_kind)
        ACC_LOAD_EX: begin
          held_d     = 1'b1;
          tag_addr_d = acc_addr;
          tag_size_d = acc_size;
        end
        ACC_STORE_EX: begin
          local_ok   = held_q && (acc_addr == tag_addr_q) && (acc_size == tag_size_q);
          held_d     = 1'b0;
          tag_addr_d = '0;
          tag_size_d = XSZ_NONE;
        end
        default: begin
          // plain load or store: drop any reservation regardless of address
          held_d     = 1'b0;
          tag_addr_d = '0;
          tag_size_d = XSZ_NONE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q     <= 1'b0;
      tag_addr_q <= '0;
      tag_size_q <= XSZ_NONE;
    end else if (acc_valid) begin
      held_q     <= held_d;
      tag_addr_q <= tag_addr_d;
      tag_size_q <= tag_size_d;
    end
  end

  assign resv_held = held_q;

  AST_LDX_TAGS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == ACC_LOAD_EX |=> held_q && tag_addr_q == $past(acc_addr) && tag_size_q == $past(acc_size)); // R2
  AST_LOAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == ACC_LOAD |=> !held_q && tag_size_q == XSZ_NONE); // R3
  AST_STORE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == ACC_STORE |=> !held_q && tag_addr_q == '0); // R4
  AST_STX_CONSUMES: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && acc_kind == ACC_STORE_EX |=> !held_q); // R5
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |=> $stable(held_q) && $stable(tag_addr_q)); // R2
endmodule

// File: rtl/excl_resp.sv
module excl_resp
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  acc_kind_e         acc_kind,
  input  xfer_size_e        acc_size,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              local_ok,
  input  logic              global_ok,
  output logic              status_valid,
  output logic              status_code,
  output logic              local_pass,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  localparam int BYTE_BITS = (DATA_W < 8)  ? DATA_W : 8;
  localparam int HALF_BITS = (DATA_W < 16) ? DATA_W : 16;

  function automatic logic [DATA_W-1:0] zext(input logic [DATA_W-1:0] d, input xfer_size_e s);
    int lim;
    logic [DATA_W-1:0] r;
    unique case (s)
      XSZ_BYTE: lim = BYTE_BITS;
      XSZ_HALF: lim = HALF_BITS;
      default:  lim = DATA_W;
    endcase
    for (int i = 0; i < DATA_W; i++) r[i] = (i < lim) ? d[i] : 1'b0;
    return r;
  endfunction

  logic stx_fire, ldx_fire, commit;
  logic sv_d, code_d, lp_d, we_d, lv_d;
  logic sv_q, code_q, lp_q, we_q, lv_q;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] wdata_q, wdata_d, ldd_q, ldd_d;

  always_comb begin
    stx_fire = acc_valid && (acc_kind == ACC_STORE_EX);
    ldx_fire = acc_valid && (acc_kind == ACC_LOAD_EX);
    commit   = stx_fire && local_ok && global_ok;
    sv_d     = stx_fire;
    code_d   = stx_fire ? !(local_ok && global_ok) : code_q;
    lp_d     = stx_fire ? local_ok : lp_q;
    we_d     = commit;
    addr_d   = commit ? acc_addr : addr_q;
    wdata_d  = commit ? zext(st_data, acc_size) : wdata_q;
    lv_d     = ldx_fire;
    ldd_d    = ldx_fire ? zext(rd_data, acc_size) : ldd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv_q    <= 1'b0;
      code_q  <= 1'b0;
      lp_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      lv_q    <= 1'b0;
      ldd_q   <= '0;
    end else begin
      sv_q <= sv_d;
      we_q <= we_d;
      lv_q <= lv_d;
      if (stx_fire) begin
        code_q <= code_d;
        lp_q   <= lp_d;
      end
      if (commit) begin
        addr_q  <= addr_d;
        wdata_q <= wdata_d;
      end
      if (ldx_fire) ldd_q <= ldd_d;
    end
  end

  assign status_valid = sv_q;
  assign status_code  = code_q;
  assign local_pass   = lp_q;
  assign mem_we       = we_q;
  assign mem_addr     = addr_q;
  assign mem_wdata    = wdata_q;
  assign ld_valid     = lv_q;
  assign ld_data      = ldd_q;

  AST_WE_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    stx_fire && !(local_ok && global_ok) |=> !mem_we && status_code); // R7
  AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we); // R8
  AST_STATUS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    stx_fire |=> status_valid); // R8
  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    ldx_fire && acc_size == XSZ_BYTE |=> ld_valid && ld_data[DATA_W-1:BYTE_BITS] == '0); // R10
endmodule

// File: rtl/excl_monitor.sv
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_size,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [ADDR_W-1:0] ra_val,
  input  logic [ADDR_W-1:0] rb_val,
  input  logic [DATA_W-1:0] st_data,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              global_pass,
  output logic              status_valid,
  output logic              status_code,
  output logic              local_pass,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_data
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [ADDR_W-1:0] eff_addr;
  logic              resv_held, local_ok;
  acc_kind_e         kind;
  xfer_size_e        size;

  // reset asserts at once, releases after two clean edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  assign kind = acc_kind_e'(req_kind);
  assign size = xfer_size_e'(req_size);

  excl_ea_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ea (
    .ra_idx   (ra_idx),
    .ra_val   (ra_val),
    .rb_val   (rb_val),
    .eff_addr (eff_addr)
  );

  excl_resv #(.ADDR_W(ADDR_W)) u_resv (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .acc_valid (req_valid),
    .acc_kind  (kind),
    .acc_addr  (eff_addr),
    .acc_size  (size),
    .resv_held (resv_held),
    .local_ok  (local_ok)
  );

  excl_resp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_resp (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .acc_valid    (req_valid),
    .acc_kind     (kind),
    .acc_size     (size),
    .acc_addr     (eff_addr),
    .st_data      (st_data),
    .rd_data      (mem_rdata),
    .local_ok     (local_ok),
    .global_ok    (global_pass),
    .status_valid (status_valid),
    .status_code  (status_code),
    .local_pass   (local_pass),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .ld_valid     (ld_valid),
    .ld_data      (ld_data)
  );

  AST_FREE_STX_FAILS: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && kind == ACC_STORE_EX && !resv_held |=> status_code && !local_pass && !mem_we); // R6
  AST_ZERO_BASE: assert property (@(posedge clk) disable iff (!rst_int_n)
    req_valid && kind == ACC_STORE_EX && ra_idx == '0 && local_ok && global_pass |=> mem_addr == $past(rb_val)); // R9
endmodule

// File: tb/excl_monitor_tb.sv
module excl_monitor_tb;
  logic        clk, rst_n, req_valid, global_pass;
  logic [1:0]  req_kind, req_size;
  logic [4:0]  ra_idx;
  logic [31:0] ra_val, rb_val, st_data, mem_rdata;
  logic        status_valid, status_code, local_pass, mem_we, ld_valid;
  logic [31:0] mem_addr, mem_wdata, ld_data;
  int checks = 0;
  int errors = 0;

  excl_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_size(req_size), .ra_idx(ra_idx), .ra_val(ra_val), .rb_val(rb_val),
    .st_data(st_data), .mem_rdata(mem_rdata), .global_pass(global_pass),
    .status_valid(status_valid), .status_code(status_code), .local_pass(local_pass),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .ld_valid(ld_valid), .ld_data(ld_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic [1:0]  kind;
    logic [4:0]  idx;
    logic [31:0] ra, rb;
    logic [1:0]  sz;
    logic        gp;
    logic [31:0] wd, rd;
    logic        e_sv, e_code, e_lp, e_we, e_lv;
    logic [31:0] e_ld, e_addr, e_wd;
  } vec_t;

  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // R2 R10: reserve word 0x1010
    '{2'd2, 5'd3, 32'h1000, 32'h10, 2'd3, 1'b0, 32'h0, 32'hDEADBEEF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDEADBEEF, 32'h0, 32'h0},
    // R2 R7 R8: matching conditional commits
    '{2'd3, 5'd3, 32'h1000, 32'h10, 2'd3, 1'b1, 32'h11223344, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h1010, 32'h11223344},
    // R5: reservation consumed
    '{2'd3, 5'd3, 32'h1000, 32'h10, 2'd3, 1'b1, 32'h55, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    // R9 R10: zero base, byte zero-extend
    '{2'd2, 5'd0, 32'h5555, 32'h200, 2'd1, 1'b0, 32'h0, 32'hAABBCCDD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hDD, 32'h0, 32'h0},
    // R9 R8: zero base ignores ra_val, byte data masked
    '{2'd3, 5'd0, 32'h9999, 32'h200, 2'd1, 1'b1, 32'hFFFFFF5A, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h200, 32'h5A},
    // R10: halfword zero-extend
    '{2'd2, 5'd1, 32'h40, 32'h0, 2'd2, 1'b0, 32'h0, 32'h1234ABCD, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hABCD, 32'h0, 32'h0},
    // R5: size mismatch fails
    '{2'd3, 5'd1, 32'h40, 32'h0, 2'd3, 1'b1, 32'h7, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    '{2'd2, 5'd1, 32'h40, 32'h0, 2'd2, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0},
    // R5: address mismatch fails
    '{2'd3, 5'd1, 32'h44, 32'h0, 2'd2, 1'b1, 32'h7, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    '{2'd2, 5'd1, 32'h80, 32'h0, 2'd3, 1'b0, 32'h0, 32'hCAFEF00D, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hCAFEF00D, 32'h0, 32'h0},
    // R3: unrelated plain load
    '{2'd0, 5'd1, 32'h300, 32'h0, 2'd3, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    '{2'd3, 5'd1, 32'h80, 32'h0, 2'd3, 1'b1, 32'h7, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    '{2'd2, 5'd1, 32'h80, 32'h0, 2'd3, 1'b0, 32'h0, 32'h1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h1, 32'h0, 32'h0},
    // R4: unrelated plain store
    '{2'd1, 5'd1, 32'h999, 32'h0, 2'd3, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    '{2'd3, 5'd1, 32'h80, 32'h0, 2'd3, 1'b1, 32'h7, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    '{2'd2, 5'd1, 32'h80, 32'h0, 2'd3, 1'b0, 32'h0, 32'h2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h2, 32'h0, 32'h0},
    // R7: global veto, local still passes
    '{2'd3, 5'd1, 32'h80, 32'h0, 2'd3, 1'b0, 32'h7, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    // R5: vetoed attempt still consumed it
    '{2'd3, 5'd1, 32'h80, 32'h0, 2'd3, 1'b1, 32'h7, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    '{2'd2, 5'd1, 32'h80, 32'h0, 2'd3, 1'b0, 32'h0, 32'h3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h3, 32'h0, 32'h0},
    // R2: re-reserve moves the tag
    '{2'd2, 5'd1, 32'h90, 32'h0, 2'd1, 1'b0, 32'h0, 32'h1FF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'hFF, 32'h0, 32'h0},
    '{2'd3, 5'd1, 32'h80, 32'h0, 2'd3, 1'b1, 32'h7, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 32'h0},
    '{2'd2, 5'd1, 32'h90, 32'h0, 2'd1, 1'b0, 32'h0, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 32'h0, 32'h0, 32'h0},
    '{2'd3, 5'd1, 32'h90, 32'h0, 2'd1, 1'b1, 32'h1234, 32'h0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 32'h0, 32'h90, 32'h34}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] k, input logic [4:0] i, input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] s, input logic g, input logic [31:0] w, input logic [31:0] r);
    req_valid = 1'b1; req_kind = k; ra_idx = i; ra_val = a; rb_val = b;
    req_size = s; global_pass = g; st_data = w; mem_rdata = r;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R8 watchdog actual hang expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    req_valid = 1'b0; req_kind = 2'd0; req_size = 2'd0; ra_idx = '0;
    ra_val = '0; rb_val = '0; st_data = '0; mem_rdata = '0; global_pass = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    // R1: outputs cleared while reset is held
    check("R1 status_valid", {31'd0, status_valid}, 32'd0);
    check("R1 mem_we", {31'd0, mem_we}, 32'd0);
    check("R1 ld_data", ld_data, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 R6: conditional at reset tag (address 0, size code 0) must fail
    drive(2'd3, 5'd0, 32'h0, 32'h0, 2'd0, 1'b1, 32'hAB, 32'h0);
    check("R1 status_code", {31'd0, status_code}, 32'd1);
    check("R6 local_pass", {31'd0, local_pass}, 32'd0);
    check("R6 mem_we", {31'd0, mem_we}, 32'd0);

    for (int n = 0; n < NV; n++) begin
      vec_t v;
      v = VECS[n];
      drive(v.kind, v.idx, v.ra, v.rb, v.sz, v.gp, v.wd, v.rd);
      check("R8 status_valid", {31'd0, status_valid}, {31'd0, v.e_sv});
      check("R7 mem_we", {31'd0, mem_we}, {31'd0, v.e_we});
      check("R10 ld_valid", {31'd0, ld_valid}, {31'd0, v.e_lv});
      if (v.e_sv) begin
        check("R5 status_code", {31'd0, status_code}, {31'd0, v.e_code});
        check("R7 local_pass", {31'd0, local_pass}, {31'd0, v.e_lp});
      end
      if (v.e_we) begin
        check("R9 mem_addr", mem_addr, v.e_addr);
        check("R8 mem_wdata", mem_wdata, v.e_wd);
      end
      if (v.e_lv) check("R10 ld_data", ld_data, v.e_ld);
    end

    // R8 R2: idle cycle keeps the reservation, strobes last one cycle
    drive(2'd2, 5'd2, 32'h500, 32'h0, 2'd3, 1'b0, 32'h0, 32'h9);
    @(posedge clk); @(negedge clk);
    check("R8 ld_valid drops", {31'd0, ld_valid}, 32'd0);
    check("R8 status idle", {31'd0, status_valid}, 32'd0);
    drive(2'd3, 5'd2, 32'h500, 32'h0, 2'd3, 1'b1, 32'h77, 32'h0);
    check("R2 pass after idle", {31'd0, status_code}, 32'd0);
    check("R8 mem_we pulse", {31'd0, mem_we}, 32'd1);
    @(posedge clk); @(negedge clk);
    check("R8 mem_we single", {31'd0, mem_we}, 32'd0);
    check("R8 status single", {31'd0, status_valid}, 32'd0);

    // R1: reset in the middle of a reservation drops it
    drive(2'd2, 5'd2, 32'h600, 32'h0, 2'd3, 1'b0, 32'h0, 32'h0);
    do_reset();
    drive(2'd3, 5'd2, 32'h600, 32'h0, 2'd3, 1'b1, 32'h1, 32'h0);
    check("R1 reset drops reservation", {31'd0, status_code}, 32'd1);
    check("R1 no write after reset", {31'd0, mem_we}, 32'd0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule